// File: doc/BRIEF.md
# Dual-Channel Hiccup Fault Sequencer

This block is the digital sequencer for two linear regulator channels. Each channel has an amplifier-enable output. That output may be high only when three conditions hold: the supply has been reported valid, the channel's active-low shutdown pin is high, and the channel's fault state machine allows it. An external comparator reports supply validity. Two further external comparators report, one per channel, when the regulated output has fallen below 80 % of nominal.

A single start-up hold-off timer is shared by the two channels. It is started when the supply becomes valid, and it is started again whenever either channel is switched on. While it runs, the undervoltage flags cannot push a channel into fault mode.

Outside the hold-off, an undervoltage flag on a regulating channel starts hiccup mode. In hiccup mode the enable is pulsed: it is high for `ON_CYCLES` and low for `OFF_RATIO` times as long. The channel recovers only when its flag is found clear near the end of an on-pulse. Normal regulation then resumes when the following off-period ends.

All times are clock counts set by parameters. The defaults give a 60 ms hold-off and a 1 ms on-pulse at 250 MHz.

Top module: `hiccup_seq`

## Requirements
- R1: Both `amp_en` bits are 0 whenever the synchronised supply-valid flag is 0. Every input passes through two flip-flops. A change on `supply_ok_a` therefore reaches the logic two clocks later. After supply becomes valid, a running channel raises its enable one clock after that.
- R2: A 0 on `run_a[i]` forces `amp_en[i]` and `hiccup[i]` to 0 as soon as it is synchronised. It also returns the channel to idle, so that no fault state is left over.
- R3: The hold-off lasts `HOLD_CYCLES` clocks. It starts when the synchronised supply flag rises. It starts again when either synchronised run input rises while supply is valid. Restarting it because of one channel also blocks fault entry on the other channel.
- R4: While the hold-off runs, `uv_a` has no effect on a regulating channel. A channel whose flag is still set when the hold-off ends enters hiccup mode on the next clock.
- R5: Hiccup mode starts with an off-period. It then alternates on-periods of `ON_CYCLES` clocks with off-periods of `ON_CYCLES*OFF_RATIO` clocks. The default ratio is 40.
- R6: The undervoltage flag is sampled only in the last clock of each on-period. If it is clear at that point, the channel returns to normal regulation, with its enable high, when the following off-period ends. If it is set, another on-period follows.
- R7: Outside the hold-off, a regulating channel enters hiccup mode on the clock after its synchronised undervoltage flag is seen high. On that clock its enable goes low.
- R8: `hiccup[i]` is 1 exactly while channel i is in hiccup mode, during both its on-periods and its off-periods.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| supply_ok_a | input | 1 | Supply-valid flag, asynchronous |
| run_a | input | 2 | Per-channel run pin; 0 shuts the channel down, asynchronous |
| uv_a | input | 2 | Per-channel undervoltage flag; 1 means output below 80 % of nominal, asynchronous |
| amp_en | output | 2 | Per-channel amplifier enable |
| hiccup | output | 2 | Per-channel hiccup-mode status |

## Verification
The port-level assertions assume that each asynchronous input holds its level for at least the two synchroniser clocks. Under that assumption, the value of an input two clocks earlier is the value the logic acts on. The stimulus changes inputs only at falling clock edges and holds every level for several clocks, so no pulse is shorter than the synchroniser. The bench keeps the hold-off and the on-pulse small, so that several full hiccup periods, recoveries and hold-off restarts fit into one short run.

// File: rtl/hiccup_seq.sv
module hiccup_seq #(
  parameter int ON_CYCLES   = 250_000,
  parameter int OFF_RATIO   = 40,
  parameter int HOLD_CYCLES = 15_000_000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       supply_ok_a,
  input  logic [1:0] run_a,
  input  logic [1:0] uv_a,
  output logic [1:0] amp_en,
  output logic [1:0] hiccup
);
  localparam int OFF_CYCLES = ON_CYCLES * OFF_RATIO;
  localparam int CW = $clog2(OFF_CYCLES + 1);
  localparam int HW = $clog2(HOLD_CYCLES + 1);

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_ON, S_OFF} ch_state_t;

  logic [4:0] meta1, meta2;
  logic       sup_s, sup_q, kick, holding;
  logic [1:0] run_s, run_q, uv_s;
  logic [HW-1:0] hold_cnt;
  ch_state_t     st  [2];
  logic [CW-1:0] cnt [2];
  logic [1:0]    ok;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      meta1 <= '0;
      meta2 <= '0;
    end else begin
      meta1 <= {supply_ok_a, run_a, uv_a};
      meta2 <= meta1;
    end

  assign sup_s   = meta2[4];
  assign run_s   = meta2[3:2];
  assign uv_s    = meta2[1:0];
  assign kick    = sup_s & (~sup_q | (|(run_s & ~run_q)));
  assign holding = (hold_cnt != '0) | kick;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sup_q    <= 1'b0;
      run_q    <= '0;
      hold_cnt <= '0;
    end else begin
      sup_q <= sup_s;
      run_q <= run_s;
      if (!sup_s)              hold_cnt <= '0;
      else if (kick)           hold_cnt <= HW'(HOLD_CYCLES);
      else if (hold_cnt != '0) hold_cnt <= hold_cnt - 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < 2; i++) begin
        st[i]  <= S_IDLE;
        cnt[i] <= '0;
        ok[i]  <= 1'b0;
      end
    end else begin
      for (int i = 0; i < 2; i++) begin
        if (!sup_s || !run_s[i]) begin
          st[i]  <= S_IDLE;
          cnt[i] <= '0;
          ok[i]  <= 1'b0;
        end else begin
          case (st[i])
            S_IDLE: st[i] <= S_RUN;
            S_RUN:
              if (!holding && uv_s[i]) begin
                st[i]  <= S_OFF;
                cnt[i] <= CW'(OFF_CYCLES - 1);
                ok[i]  <= 1'b0;
              end
            S_ON:
              if (cnt[i] == '0) begin
                ok[i]  <= ~uv_s[i];
                st[i]  <= S_OFF;
                cnt[i] <= CW'(OFF_CYCLES - 1);
              end else cnt[i] <= cnt[i] - 1'b1;
            default:
              if (cnt[i] == '0) begin
                if (ok[i]) st[i] <= S_RUN;
                else begin
                  st[i]  <= S_ON;
                  cnt[i] <= CW'(ON_CYCLES - 1);
                end
              end else cnt[i] <= cnt[i] - 1'b1;
          endcase
        end
      end
    end

  for (genvar g = 0; g < 2; g++) begin : g_ch
    logic live;
    assign live      = sup_s & run_s[g];
    assign amp_en[g] = live & ((st[g] == S_RUN) | (st[g] == S_ON));
    assign hiccup[g] = live & ((st[g] == S_ON) | (st[g] == S_OFF));

    p_shutdown_forces_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(run_a[g], 2) |-> (!amp_en[g] && !hiccup[g]));
    p_hold_blocks_entry_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (holding && !hiccup[g]) |=> !hiccup[g]);
    p_entry_is_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hiccup[g]) |-> !amp_en[g]);
    p_exit_after_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(hiccup[g]) && amp_en[g]) |-> $past(!amp_en[g]));
  end

  p_supply_gates_all_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(supply_ok_a, 2) |-> (amp_en == 2'b00));
endmodule

// File: tb/hiccup_seq_bench.sv
`timescale 1ns/1ps
module hiccup_seq_bench;
  localparam int ON  = 4;
  localparam int RAT = 40;
  localparam int OFF = ON * RAT;
  localparam int HLD = 50;

  logic clk = 0, rst_n = 0, sup = 0;
  logic [1:0] run = 2'b11, uv = 2'b00;
  logic [1:0] amp_en, hiccup;
  int checks = 0, errors = 0;
  string tag = "R1";
  bit done = 0;

  hiccup_seq #(.ON_CYCLES(ON), .OFF_RATIO(RAT), .HOLD_CYCLES(HLD)) u_hiccup_seq (
    .clk(clk), .rst_n(rst_n), .supply_ok_a(sup), .run_a(run), .uv_a(uv),
    .amp_en(amp_en), .hiccup(hiccup));

  always #2 clk = ~clk;

  // behavioural reference: mode 0 idle, 1 normal, 2 pulse high, 3 pulse low
  int d1[5], d2[5];
  int m_supq, m_runq[2], m_hold, mode[2], left[2], good[2];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < 5; k++) begin d1[k] = 0; d2[k] = 0; end
      m_supq = 0; m_hold = 0;
      for (int c = 0; c < 2; c++) begin m_runq[c] = 0; mode[c] = 0; left[c] = 0; good[c] = 0; end
    end else begin
      int s, r[2], u[2], start, busy;
      s = d2[0]; r[0] = d2[1]; r[1] = d2[2]; u[0] = d2[3]; u[1] = d2[4];
      start = s && (!m_supq || (r[0] && !m_runq[0]) || (r[1] && !m_runq[1]));
      busy = (m_hold > 0) || start;
      for (int c = 0; c < 2; c++) begin
        if (!s || !r[c]) begin mode[c] = 0; left[c] = 0; good[c] = 0; end
        else if (mode[c] == 0) mode[c] = 1;
        else if (mode[c] == 1) begin
          if (!busy && u[c]) begin mode[c] = 3; left[c] = OFF; good[c] = 0; end
        end else if (mode[c] == 2) begin
          left[c]--;
          if (left[c] == 0) begin good[c] = !u[c]; mode[c] = 3; left[c] = OFF; end
        end else begin
          left[c]--;
          if (left[c] == 0) begin
            if (good[c]) mode[c] = 1; else begin mode[c] = 2; left[c] = ON; end
          end
        end
      end
      if (!s) m_hold = 0; else if (start) m_hold = HLD; else if (m_hold > 0) m_hold--;
      m_supq = s; m_runq[0] = r[0]; m_runq[1] = r[1];
      for (int k = 0; k < 5; k++) d2[k] = d1[k];
      d1[0] = sup; d1[1] = run[0]; d1[2] = run[1]; d1[3] = uv[0]; d1[4] = uv[1];
    end
  end

  function automatic logic [1:0] exp_en();
    for (int c = 0; c < 2; c++)
      exp_en[c] = d2[0] && d2[1+c] && (mode[c] == 1 || mode[c] == 2);
  endfunction
  function automatic logic [1:0] exp_hic();
    for (int c = 0; c < 2; c++)
      exp_hic[c] = d2[0] && d2[1+c] && (mode[c] == 2 || mode[c] == 3);
  endfunction

  always @(negedge clk) if (rst_n && !done) begin
    checks++;
    if (amp_en !== exp_en() || hiccup !== exp_hic()) begin
      errors++;
      $display("FAIL %s model: en=%b hic=%b expected en=%b hic=%b", tag, amp_en, hiccup, exp_en(), exp_hic());
    end
  end

  task automatic tick(int n); repeat (n) @(negedge clk); endtask
  task automatic chk(string req, logic [1:0] act, logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic finish_run();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    int hi, lo;
    tick(5);
    rst_n = 1;
    tag = "R1";
    tick(20);
    chk("R1 reset no supply", amp_en, 2'b00);
    chk("R8 reset status", hiccup, 2'b00);
    sup = 1; tag = "R3";
    tick(2);
    chk("R1 sync latency", amp_en, 2'b00);
    tick(1);
    chk("R1 enable after supply", amp_en, 2'b11);
    tag = "R4";
    tick(7);
    uv[0] = 1;
    tick(30);
    chk("R4 ignored in hold-off", hiccup, 2'b00);
    tick(40);
    chk("R4 fault at hold-off end", hiccup, 2'b01);
    tag = "R6";
    uv[0] = 0;
    tick(400);
    chk("R6 recovered", hiccup, 2'b00);
    chk("R6 enable restored", amp_en, 2'b11);
    tag = "R7";
    uv[1] = 1;
    tick(3);
    chk("R7 R8 entry outside hold-off", hiccup, 2'b10);
    chk("R7 enable dropped", amp_en, 2'b01);
    tag = "R5";
    hi = 0; lo = 0;
    for (int w = 0; w < 300 && !amp_en[1]; w++) tick(1);
    while (amp_en[1] && hi < 1000) begin hi++; tick(1); end
    while (!amp_en[1] && lo < 1000) begin lo++; tick(1); end
    checks++;
    if (hi != ON) begin errors++; $display("FAIL R5 on-time: got %0d expected %0d", hi, ON); end
    checks++;
    if (lo != OFF) begin errors++; $display("FAIL R5 off-time: got %0d expected %0d", lo, OFF); end
    tag = "R6";
    uv[1] = 0;
    tick(400);
    chk("R6 channel 1 recovered", hiccup, 2'b00);
    tag = "R3";
    run[1] = 0;
    tick(6);
    chk("R2 channel 1 off", amp_en, 2'b01);
    run[1] = 1;
    tick(1);
    uv[0] = 1;
    tick(30);
    chk("R3 shared hold-off protects channel 0", hiccup, 2'b00);
    tick(40);
    chk("R3 channel 0 fault after restart", hiccup, 2'b01);
    tag = "R2";
    run[0] = 0;
    tick(3);
    chk("R2 shutdown clears enable", amp_en[0], 1'b0);
    chk("R2 shutdown clears status", hiccup, 2'b00);
    uv[0] = 0;
    run[0] = 1;
    tick(100);
    chk("R2 restart normal", amp_en, 2'b11);
    tag = "R1";
    sup = 0;
    tick(3);
    chk("R1 supply loss", amp_en, 2'b00);
    chk("R1 supply loss status", hiccup, 2'b00);
    tick(10);
    tag = "R4";
    uv[1] = 1;
    sup = 1;
    tick(70);
    chk("R4 power-up into fault", hiccup, 2'b10);
    chk("R4 healthy channel runs", amp_en[0], 1'b1);
    tick(20);
    finish_run();
  end
endmodule